// File: doc/BRIEF.md
# Break-Aware Two-Channel Capture/Compare Timer

This block is a free-running up-counter with a set of capture/compare channels and a small byte-wide register bus. Each channel is set up on its own either to latch the counter value on a rising edge at its pin, or to toggle its pin when the counter equals a stored value. A status register holds one flag for counter wrap-around and one flag per channel.

A status flag is cleared in two steps. First a bus read of the status register arms every flag that reads as 1. Then a bus write of 0 to an armed flag's bit clears it. A debug-break input freezes the counter. While break is active, the flags are protected: reads neither arm nor disarm, and writes do not clear. The exception is when a break-clear-enable input allows clearing. An arming done before a break survives it, so the second step can finish the job once the break ends.

Channel pins are treated as synchronous to `clk`. The direction select of each channel pin follows that channel's mode.

Top module: `brk_timer`

## Requirements
- R1: The counter adds 1 (modulo 2^CNT_W) on every clock edge where `brk_active` is 0, and holds its value while `brk_active` is 1. The counter is readable as a low byte at address 2 and high bits at address 3.
- R2: On the edge where the counter goes from its all-ones value to 0, the wrap flag (status bit 0, address 0) is set.
- R3: A read of address 0 arms each flag that is 1 at that time, and disarms each flag that is 0. A write to address 0 clears an armed flag whose data bit is 0. A write of 0 to a flag that is not armed leaves it set. Writing 1 has no effect.
- R4: When a flag's set event falls on the same edge as a clearing write, the flag stays 1 and its arming is dropped. A later write of 0 without a new read then leaves the flag set.
- R5: While `brk_active`=1 and `brk_clr_en`=0, status reads neither arm nor disarm, and status writes clear nothing. An arming made before the break stays, and a write of 0 after the break then clears the flag.
- R6: While `brk_active`=1 and `brk_clr_en`=1, the two-step clear works as usual, and a flag cleared this way still reads 0 after the break ends.
- R7: In capture mode (control bit k = 0, address 1), a rising edge on `ch_in[k]` copies the counter into channel k's value register and sets status bit k+1. The value register is read and written at address 4+2k (low byte) and 5+2k (high bits).
- R8: In compare mode (control bit k = 1), on each edge where the counter is not frozen and equals channel k's value, `ch_out[k]` toggles and status bit k+1 is set. `ch_oe[k]` equals control bit k.
- R9: After reset, the counter, flags, armings, modes, value registers, `ch_out`, `ch_oe` and `bus_rdata` are all 0.
- R10: `bus_rdata` is loaded on the edge where `bus_rd` is 1, with the value the addressed register held before that edge, and it holds between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| brk_active | input | 1 | Debug break in progress |
| brk_clr_en | input | 1 | Allow flag clearing during break |
| ch_in | input | NCH | Channel pin inputs |
| ch_out | output | NCH | Channel pin outputs |
| ch_oe | output | NCH | Channel pin direction, 1 = driven |

## Verification
The bench builds the block with CNT_W = 10 and NCH = 2. A 10-bit counter wraps every 1024 active cycles, so a run can reach the wrap flag several times. This lets the bench arrange a clearing write to fall on the exact edge of a wrap, and it brings the break-protection and break-enabled clearing cases within a short run. With two channels, one channel can stay in capture mode while the other runs in compare mode, which checks that the per-channel mode and pin direction are independent.

// File: rtl/brk_timer_pkg.sv
package brk_timer_pkg;
  localparam int unsigned BUS_AW = 4;
  localparam logic [BUS_AW-1:0] A_STAT     = 4'h0;
  localparam logic [BUS_AW-1:0] A_CTRL     = 4'h1;
  localparam logic [BUS_AW-1:0] A_CNT_LO   = 4'h2;
  localparam logic [BUS_AW-1:0] A_CNT_HI   = 4'h3;
  localparam int unsigned       A_VAL_BASE = 4;
endpackage

// File: rtl/brk_timer_counter.sv
module brk_timer_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          brk,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  assign wrap = !brk && (&cnt);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (!brk) cnt <= cnt + CW'(1);
  end

  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    brk |=> cnt == $past(cnt));
  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    !brk |=> cnt == $past(cnt) + CW'(1));
endmodule

// File: rtl/brk_timer_flag.sv
module brk_timer_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic rd_arm,
  input  logic wr_clr,
  input  logic allow,
  output logic flag
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else if (set_evt) begin
      flag  <= 1'b1;
      armed <= 1'b0;
    end else if (allow && wr_clr && armed && flag) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else if (allow && rd_arm) begin
      armed <= flag;
    end
  end

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> flag && !armed);
  // R3
  no_arm_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !armed && !set_evt) |=> flag);
  // R5
  brk_protect_chk: assert property (@(posedge clk) disable iff (rst)
    (!allow && !set_evt) |=> $stable(flag) && $stable(armed));
endmodule

// File: rtl/brk_timer_channel.sv
module brk_timer_channel #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          brk,
  input  logic          mode,
  input  logic [CW-1:0] cnt,
  input  logic          pin_in,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [7:0]    wdata,
  output logic [CW-1:0] val,
  output logic          pin_out,
  output logic          evt
);
  localparam int unsigned HW = CW - 8;

  logic in_q;
  logic rise;
  logic match;

  assign rise  = pin_in && !in_q;
  assign match = !brk && (cnt == val);
  assign evt   = mode ? match : rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q    <= 1'b0;
      val     <= '0;
      pin_out <= 1'b0;
    end else begin
      in_q <= pin_in;
      if (!mode && rise) begin
        val <= cnt;
      end else begin
        if (wr_lo) val[7:0]    <= wdata;
        if (wr_hi) val[CW-1:8] <= wdata[HW-1:0];
      end
      if (mode && match) pin_out <= !pin_out;
    end
  end

  // R7
  cap_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode && rise) |=> val == $past(cnt));
  // R8
  cmp_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (mode && match) |=> pin_out != $past(pin_out));
endmodule

// File: rtl/brk_timer.sv
module brk_timer
  import brk_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned NCH   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              brk_active,
  input  logic              brk_clr_en,
  input  logic [NCH-1:0]    ch_in,
  output logic [NCH-1:0]    ch_out,
  output logic [NCH-1:0]    ch_oe
);
  localparam int unsigned NF = NCH + 1;

  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic [NCH-1:0]   mode_q;
  logic [NF-1:0]    flags;
  logic [NF-1:0]    set_evt;
  logic [NCH-1:0]   ch_evt;
  logic [CNT_W-1:0] ch_val [NCH];
  logic             stat_rd, stat_wr, allow;
  logic [7:0]       rd_mux;

  assign stat_rd = bus_rd && (bus_addr == A_STAT);
  assign stat_wr = bus_wr && (bus_addr == A_STAT);
  assign allow   = !brk_active || brk_clr_en;
  assign set_evt = {ch_evt, wrap};
  assign ch_oe   = mode_q;

  brk_timer_counter #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .brk(brk_active), .cnt(cnt), .wrap(wrap)
  );

  for (genvar i = 0; i < NF; i++) begin : g_flag
    brk_timer_flag u_flag (
      .clk(clk), .rst(rst), .set_evt(set_evt[i]), .rd_arm(stat_rd),
      .wr_clr(stat_wr && !bus_wdata[i]), .allow(allow), .flag(flags[i])
    );
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    localparam logic [BUS_AW-1:0] LO_A = BUS_AW'(A_VAL_BASE + 2*k);
    localparam logic [BUS_AW-1:0] HI_A = BUS_AW'(A_VAL_BASE + 2*k + 1);
    brk_timer_channel #(.CW(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .brk(brk_active), .mode(mode_q[k]), .cnt(cnt),
      .pin_in(ch_in[k]),
      .wr_lo(bus_wr && (bus_addr == LO_A)),
      .wr_hi(bus_wr && (bus_addr == HI_A)),
      .wdata(bus_wdata), .val(ch_val[k]), .pin_out(ch_out[k]), .evt(ch_evt[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)                                   mode_q <= '0;
    else if (bus_wr && (bus_addr == A_CTRL))   mode_q <= bus_wdata[NCH-1:0];
  end

  always_comb begin
    rd_mux = 8'h00;
    case (bus_addr)
      A_STAT:   rd_mux[NF-1:0]  = flags;
      A_CTRL:   rd_mux[NCH-1:0] = mode_q;
      A_CNT_LO: rd_mux          = cnt[7:0];
      A_CNT_HI: rd_mux          = 8'(cnt >> 8);
      default:  rd_mux          = 8'h00;
    endcase
    for (int k = 0; k < NCH; k++) begin
      if (bus_addr == BUS_AW'(A_VAL_BASE + 2*k))     rd_mux = ch_val[k][7:0];
      if (bus_addr == BUS_AW'(A_VAL_BASE + 2*k + 1)) rd_mux = 8'(ch_val[k] >> 8);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= 8'h00;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
  // R8
  oe_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_CTRL) |=> ch_oe == $past(bus_wdata[NCH-1:0]));
endmodule

// File: tb/tb_brk_timer.sv
module tb_brk_timer;
  localparam int CW  = 10;
  localparam int NCH = 2;
  localparam int NF  = NCH + 1;
  localparam int MAX = (1 << CW) - 1;

  logic clk = 0, rst = 1;
  logic [3:0] bus_addr = 0;
  logic bus_rd = 0, bus_wr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic brk_active = 0, brk_clr_en = 0;
  logic [NCH-1:0] ch_in = 0, ch_out, ch_oe;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  brk_timer #(.CNT_W(CW), .NCH(NCH)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .brk_active(brk_active),
    .brk_clr_en(brk_clr_en), .ch_in(ch_in), .ch_out(ch_out), .ch_oe(ch_oe)
  );

  // behavioural reference
  int m_cnt, m_rdata;
  int m_flag [NF];
  int m_arm  [NF];
  int m_val  [NCH];
  int m_out  [NCH];
  int m_prev [NCH];
  int m_mode [NCH];

  function automatic int m_read(input int a);
    int r = 0;
    if (a == 0) for (int i = 0; i < NF; i++) r |= m_flag[i] << i;
    else if (a == 1) for (int k = 0; k < NCH; k++) r |= m_mode[k] << k;
    else if (a == 2) r = m_cnt & 255;
    else if (a == 3) r = m_cnt >> 8;
    else for (int k = 0; k < NCH; k++) begin
      if (a == 4 + 2*k) r = m_val[k] & 255;
      if (a == 5 + 2*k) r = m_val[k] >> 8;
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_rdata = 0;
      for (int i = 0; i < NF; i++) begin m_flag[i] = 0; m_arm[i] = 0; end
      for (int k = 0; k < NCH; k++) begin
        m_val[k] = 0; m_out[k] = 0; m_prev[k] = 0; m_mode[k] = 0;
      end
    end else begin
      int ev [NF];
      bit ok;
      int a;
      a  = int'(bus_addr);
      ok = !brk_active || brk_clr_en;
      if (bus_rd) m_rdata = m_read(a);
      ev[0] = (!brk_active && m_cnt == MAX) ? 1 : 0;
      for (int k = 0; k < NCH; k++) begin
        if (m_mode[k] != 0) ev[k+1] = (!brk_active && m_cnt == m_val[k]) ? 1 : 0;
        else                ev[k+1] = (ch_in[k] && m_prev[k] == 0) ? 1 : 0;
      end
      for (int i = 0; i < NF; i++) begin
        if (ev[i] != 0) begin m_flag[i] = 1; m_arm[i] = 0; end
        else if (ok && bus_wr && a == 0 && !bus_wdata[i] && m_arm[i] != 0 && m_flag[i] != 0) begin
          m_flag[i] = 0; m_arm[i] = 0;
        end else if (ok && bus_rd && a == 0) m_arm[i] = m_flag[i];
      end
      for (int k = 0; k < NCH; k++) begin
        if (m_mode[k] == 0 && ev[k+1] != 0) m_val[k] = m_cnt;
        else begin
          if (bus_wr && a == 4 + 2*k) m_val[k] = (m_val[k] & ~255) | int'(bus_wdata);
          if (bus_wr && a == 5 + 2*k) m_val[k] = (m_val[k] & 255) | ((int'(bus_wdata) << 8) & MAX);
        end
        if (m_mode[k] != 0 && ev[k+1] != 0) m_out[k] ^= 1;
        m_prev[k] = ch_in[k] ? 1 : 0;
      end
      if (bus_wr && a == 1) for (int k = 0; k < NCH; k++) m_mode[k] = bus_wdata[k] ? 1 : 0;
      if (!brk_active) m_cnt = (m_cnt + 1) & MAX;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) if (!rst) begin
    chk("R10 bus_rdata", int'(bus_rdata), m_rdata);
    for (int k = 0; k < NCH; k++) begin
      chk("R8 ch_out", int'(ch_out[k]), m_out[k]);
      chk("R8 ch_oe", int'(ch_oe[k]), m_mode[k]);
    end
  end

  task automatic idle(input int n);
    bus_rd = 0; bus_wr = 0;
    repeat (n) @(negedge clk);
  endtask
  task automatic rd(input int a);
    bus_addr = 4'(a); bus_rd = 1; bus_wr = 0;
    @(negedge clk);
    bus_rd = 0;
  endtask
  task automatic wr(input int a, input int d);
    bus_addr = 4'(a); bus_wdata = 8'(d); bus_wr = 1; bus_rd = 0;
    @(negedge clk);
    bus_wr = 0;
  endtask
  task automatic wait_ovf();
    while (m_flag[0] == 0) idle(1);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int a, b;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 rdata", int'(bus_rdata), 0);
    chk("R9 ch_out", int'(ch_out), 0);
    chk("R9 ch_oe", int'(ch_oe), 0);
    rst = 0;
    rd(0); chk("R9 status", int'(bus_rdata), 0);
    rd(1); chk("R9 control", int'(bus_rdata), 0);

    // R1 count and freeze
    brk_active = 1;
    rd(2); a = int'(bus_rdata);
    idle(4);
    rd(2); b = int'(bus_rdata);
    chk("R1 frozen", b, a);
    brk_active = 0;
    rd(2); a = int'(bus_rdata);
    rd(2); b = int'(bus_rdata);
    chk("R1 step", b, (a + 1) & 255);

    // R2 wrap flag
    wait_ovf();
    wr(0, 0);               // R3 no arm, no clear
    rd(0); chk("R2 wrap flag", int'(bus_rdata), 1);
    wr(0, 8'hFF);           // R3 writing 1 does nothing
    rd(0); chk("R3 write one", int'(bus_rdata), 1);
    wr(0, 8'hFE);           // R3 armed, bit 0 written 0
    rd(0); chk("R3 cleared", int'(bus_rdata), 0);

    // R5 arming kept across break
    wait_ovf();
    rd(0);
    brk_active = 1; brk_clr_en = 0;
    wr(0, 0);
    rd(0); chk("R5 protected", int'(bus_rdata), 1);
    brk_active = 0;
    wr(0, 0);
    rd(0); chk("R5 cleared after break", int'(bus_rdata), 0);

    // R5 reads during break do not arm
    wait_ovf();
    brk_active = 1;
    rd(0);
    wr(0, 0);
    brk_active = 0;
    wr(0, 0);
    rd(0); chk("R5 no arm in break", int'(bus_rdata), 1);
    wr(0, 0);               // armed by previous read: clears
    rd(0); chk("R3 clear after read", int'(bus_rdata), 0);

    // R6 clearing enabled during break
    wait_ovf();
    brk_active = 1; brk_clr_en = 1;
    rd(0);
    wr(0, 0);
    brk_active = 0; brk_clr_en = 0;
    idle(3);
    rd(0); chk("R6 stays cleared", int'(bus_rdata), 0);

    // R4 set event collides with clearing write
    wait_ovf();
    rd(0);
    while (m_cnt != MAX) idle(1);
    wr(0, 0);
    wr(0, 0);
    rd(0); chk("R4 set wins", int'(bus_rdata), 1);

    // R7 capture on channel 0
    idle(7);
    ch_in[0] = 1; idle(2); ch_in[0] = 0;
    rd(0); chk("R7 channel flag", int'(bus_rdata) & 2, 2);
    rd(4); chk("R7 captured lo", int'(bus_rdata), m_val[0] & 255);
    rd(5); chk("R7 captured hi", int'(bus_rdata), m_val[0] >> 8);

    // R8 compare on channel 1
    wr(1, 2);
    a = (m_cnt + 40) & MAX;
    wr(6, a & 255);
    wr(7, a >> 8);
    idle(60);
    chk("R8 pin toggled", int'(ch_out[1]), 1);
    chk("R8 direction", int'(ch_oe), 2);
    rd(0); chk("R8 channel flag", int'(bus_rdata) & 4, 4);
    rd(1); chk("R8 control", int'(bus_rdata), 2);

    idle(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule